// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Write Target

This block acts as a serial EEPROM target on a two-wire bus (SCL clock, SDA data, with SDA driven open-drain). It samples both bus lines into the system clock domain and finds start and stop conditions. It compares the select byte that follows a start against a fixed device code and three strap pins. When the select is for a write and the byte matches, the block acknowledges it. It then acknowledges a word address byte and every data byte that follows.

Data bytes go into an eight-entry page buffer. The low three bits of the word address pick the buffer slot. A stop that follows at least one acknowledged data byte starts a timed write cycle. At the end of that cycle every buffered slot is copied into a 256-byte register array. While the cycle runs, the block ignores the bus.

A combinational peek port reads the array, and a busy output marks the write cycle. Read transfers are not supported.

Top module: `eew_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both lines pass through two synchronizing flops before edge detection, so responses lag the bus by about three system clocks.
- R2: After a start, the block acknowledges the first byte only when bits [7:4] equal 4'b1010, bits [3:1] equal `strap_i[2:0]` and bit 0 (R/W) is 0. The byte is sent MSB first. The acknowledge is `sda_oe_o` = 1 from the SCL fall after the eighth bit until the next SCL fall.
- R3: A select byte that does not match, or that has R/W = 1, is not acknowledged. No further byte is acknowledged until the next start.
- R4: After an acknowledged write select, the next byte (the word address) is acknowledged, and every data byte after it is acknowledged.
- R5: Data byte k (counting from 0) of a transfer goes to address {addr[7:3], (addr[2:0] + k) mod 8}. The page row addr[7:3] never changes within a transfer.
- R6: If more than eight data bytes are sent, later bytes overwrite the earlier bytes of the same page, and the last byte written to each slot wins.
- R7: A stop that follows at least one acknowledged data byte raises `busy_o` for exactly WR_CYCLES system clocks. The array shows the new data once `busy_o` has fallen.
- R8: A write cycle changes only the slots that received data. Every other location of the page, and of the array, keeps its value.
- R9: While `busy_o` is high, starts, stops and bytes on the bus are ignored, and `sda_oe_o` stays 0.
- R10: A stop that arrives before any data byte has been acknowledged starts no write cycle and leaves the array unchanged.
- R11: A repeated start in the middle of a write drops the buffered bytes. A stop after that writes nothing.
- R12: After reset, `sda_oe_o` = 0, `busy_o` = 0 and every array location reads 8'h00.
- R13: `peek_data_o` shows the array byte at `peek_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Hard-wired device address straps |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| busy_o | output | 1 | Timed write cycle in progress |
| peek_addr_i | input | 8 | Array read address |
| peek_data_o | output | 8 | Array read data |

## Verification
An acknowledge appears about three system clocks after the SCL fall that ends a byte. The bench therefore samples the resolved SDA line halfway through the following SCL high phase, well after it has settled. `busy_o` rises a few clocks after the stop, so the bench waits for it to fall and only then reads the array through the peek port. The length of the write cycle is measured by a monitor that counts the clocks during which `busy_o` is high and compares the count to WR_CYCLES. Selects are swept over all strap and address-bit pairs, and the expected array contents are computed from the page-wrap arithmetic.

// File: rtl/eew_pkg.sv
// Shared types for the two-wire EEPROM write target.
// Assumes: nothing beyond standard SystemVerilog.
package eew_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,   // standby, waiting for a start
        FS_SEL,    // receiving the select byte
        FS_ADDR,   // receiving the word address
        FS_DATA    // receiving data bytes
    } fstate_t;
endpackage

// File: rtl/eew_line_sync.sv
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes: the bus is slow compared with clk (several clocks per SCL phase),
// and both lines idle high.
module eew_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_s_o
);
    logic [2:0] scl_p;
    logic [2:0] sda_p;

    // two sync stages plus one history stage per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 3'b111;
            sda_p <= 3'b111;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    // event decode from the synchronized value and its previous sample
    always_comb begin
        scl_rise_o = scl_p[1] & ~scl_p[2];
        scl_fall_o = ~scl_p[1] & scl_p[2];
        start_o    = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
        stop_o     = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
        sda_s_o    = sda_p[1];
    end
endmodule

// File: rtl/eew_frame_ctl.sv
// Byte framing, select matching, acknowledge generation and page pointer.
// Assumes: events come from eew_line_sync. Bits are sampled on the SCL rise.
// Acknowledge is driven from one SCL fall to the next.
module eew_frame_ctl
    import eew_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          PAGE_AW  = 3,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_rise_i,
    input  logic                      scl_fall_i,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic                      sda_s_i,
    input  logic [2:0]                strap_i,
    input  logic                      busy_i,
    output logic                      sda_oe_o,
    output logic                      buf_clr_o,
    output logic                      buf_wr_o,
    output logic [PAGE_AW-1:0]        buf_idx_o,
    output logic [7:0]                buf_data_o,
    output logic                      commit_o,
    output logic [ADDR_W-PAGE_AW-1:0] row_o
);
    localparam int ROW_W = ADDR_W - PAGE_AW;

    fstate_t             state_q;
    logic [7:0]          sh_q;
    logic [2:0]          bitcnt_q;
    logic                byte_done_q;
    logic                ack_ph_q;
    logic                oe_q;
    logic                got_data_q;
    logic [PAGE_AW-1:0]  ptr_q;
    logic [ROW_W-1:0]    row_q;
    logic                byte_eval;
    logic                sel_ok;

    // decide on a completed byte at the SCL fall that ends it
    always_comb begin
        byte_eval = scl_fall_i & byte_done_q & ~ack_ph_q & ~busy_i & ~start_i & ~stop_i;
        sel_ok    = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !sh_q[0];
        buf_wr_o  = byte_eval && (state_q == FS_DATA);
        buf_idx_o = ptr_q;
        buf_data_o = sh_q;
        buf_clr_o = start_i & ~busy_i;
        commit_o  = stop_i & ~busy_i & got_data_q;
        row_o     = row_q;
        sda_oe_o  = oe_q;
    end

    // framing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            sh_q        <= '0;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            ack_ph_q    <= 1'b0;
            oe_q        <= 1'b0;
            got_data_q  <= 1'b0;
            ptr_q       <= '0;
            row_q       <= '0;
        end else if (busy_i) begin
            state_q     <= FS_IDLE;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            ack_ph_q    <= 1'b0;
            oe_q        <= 1'b0;
            got_data_q  <= 1'b0;
        end else if (start_i) begin
            state_q     <= FS_SEL;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            ack_ph_q    <= 1'b0;
            oe_q        <= 1'b0;
            got_data_q  <= 1'b0;
        end else if (stop_i) begin
            state_q     <= FS_IDLE;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            ack_ph_q    <= 1'b0;
            oe_q        <= 1'b0;
            got_data_q  <= 1'b0;
        end else if (scl_fall_i) begin
            if (ack_ph_q) begin
                oe_q     <= 1'b0;
                ack_ph_q <= 1'b0;
            end else if (byte_done_q) begin
                byte_done_q <= 1'b0;
                bitcnt_q    <= '0;
                case (state_q)
                    FS_SEL: begin
                        if (sel_ok) begin
                            oe_q     <= 1'b1;
                            ack_ph_q <= 1'b1;
                            state_q  <= FS_ADDR;
                        end else begin
                            state_q  <= FS_IDLE;
                        end
                    end
                    FS_ADDR: begin
                        oe_q     <= 1'b1;
                        ack_ph_q <= 1'b1;
                        row_q    <= sh_q[7:PAGE_AW];
                        ptr_q    <= sh_q[PAGE_AW-1:0];
                        state_q  <= FS_DATA;
                    end
                    FS_DATA: begin
                        oe_q       <= 1'b1;
                        ack_ph_q   <= 1'b1;
                        got_data_q <= 1'b1;
                        ptr_q      <= ptr_q + 1'b1;
                    end
                    default: state_q <= FS_IDLE;
                endcase
            end
        end else if (scl_rise_i && state_q != FS_IDLE && !ack_ph_q && !byte_done_q) begin
            sh_q <= {sh_q[6:0], sda_s_i};
            if (bitcnt_q == 3'd7) byte_done_q <= 1'b1;
            else                  bitcnt_q    <= bitcnt_q + 1'b1;
        end
    end

    // R9
    oe_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !sda_oe_o);
    // R3
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_IDLE) |-> !sda_oe_o);
    // R5
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_DATA && $past(state_q) == FS_DATA) |-> $stable(row_q));
    // R2
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall_i));
endmodule

// File: rtl/eew_page_store.sv
// Page buffer, write-cycle timer and the register array it commits into.
// Assumes: commit_i is only raised when not busy. The row is sampled on commit_i.
module eew_page_store #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_AW   = 3,
    parameter int WR_CYCLES = 50000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      buf_clr_i,
    input  logic                      buf_wr_i,
    input  logic [PAGE_AW-1:0]        buf_idx_i,
    input  logic [7:0]                buf_data_i,
    input  logic                      commit_i,
    input  logic [ADDR_W-PAGE_AW-1:0] row_i,
    input  logic [ADDR_W-1:0]         peek_addr_i,
    output logic [7:0]                peek_data_o,
    output logic                      busy_o
);
    localparam int PAGE_N = 1 << PAGE_AW;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ROW_W  = ADDR_W - PAGE_AW;
    localparam int TW     = $clog2(WR_CYCLES + 1);

    logic [7:0]        buf_q [PAGE_N];
    logic [PAGE_N-1:0] vld_q;
    logic [ROW_W-1:0]  row_q;
    logic              busy_q;
    logic [TW-1:0]     timer_q;
    logic              fire;
    logic [7:0]        mem_q [DEPTH];

    // the write cycle ends on its last counted clock
    always_comb fire = busy_q && (timer_q == TW'(WR_CYCLES - 1));

    // page buffer and valid mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE_N; i++) buf_q[i] <= '0;
        end else if (fire || buf_clr_i) begin
            vld_q <= '0;
        end else if (buf_wr_i && !busy_q) begin
            buf_q[buf_idx_i] <= buf_data_i;
            vld_q[buf_idx_i] <= 1'b1;
        end
    end

    // write-cycle timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
            row_q   <= '0;
        end else if (fire) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
        end else if (busy_q) begin
            timer_q <= timer_q + 1'b1;
        end else if (commit_i) begin
            busy_q  <= 1'b1;
            timer_q <= '0;
            row_q   <= row_i;
        end
    end

    // register array, updated only for the valid slots when the cycle ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (fire) begin
            for (int i = 0; i < PAGE_N; i++)
                if (vld_q[i]) mem_q[{row_q, PAGE_AW'(i)}] <= buf_q[i];
        end
    end

    always_comb begin
        peek_data_o = mem_q[peek_addr_i];
        busy_o      = busy_q;
    end

    // R7
    cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(timer_q) == TW'(WR_CYCLES - 1));
    // R10
    commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(commit_i) && $past(vld_q) != '0));
endmodule

// File: rtl/eew_target.sv
// Top of the two-wire EEPROM write target: sync, framing, page store.
// Assumes: SDA is open-drain outside. sda_oe_o = 1 pulls the line low.
module eew_target #(
    parameter int         ADDR_W    = 8,
    parameter int         PAGE_AW   = 3,
    parameter int         WR_CYCLES = 50000,
    parameter logic [3:0] DEV_CODE  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [7:0]        peek_data_o
);
    localparam int ROW_W = ADDR_W - PAGE_AW;

    logic                scl_rise, scl_fall, start_ev, stop_ev, sda_s;
    logic                buf_clr, buf_wr, commit;
    logic [PAGE_AW-1:0]  buf_idx;
    logic [7:0]          buf_data;
    logic [ROW_W-1:0]    row;

    eew_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev), .sda_s_o(sda_s)
    );

    eew_frame_ctl #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .DEV_CODE(DEV_CODE)) u_frame (
        .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_ev), .stop_i(stop_ev), .sda_s_i(sda_s), .strap_i(strap_i),
        .busy_i(busy_o), .sda_oe_o(sda_oe_o), .buf_clr_o(buf_clr), .buf_wr_o(buf_wr),
        .buf_idx_o(buf_idx), .buf_data_o(buf_data), .commit_o(commit), .row_o(row)
    );

    eew_page_store #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr_i(buf_clr), .buf_wr_i(buf_wr),
        .buf_idx_i(buf_idx), .buf_data_i(buf_data), .commit_i(commit), .row_i(row),
        .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o), .busy_o(busy_o)
    );
endmodule

// File: tb/eew_target_test.sv
module eew_target_test;
    localparam int WRC = 600;
    localparam int H   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [7:0] peek_addr = '0;
    logic [7:0] peek_data;
    logic       sda_oe;
    logic       busy;
    logic       sda_line;
    logic [7:0] exp_mem [256];
    int         checks = 0;
    int         errors = 0;
    int         busy_run = 0;
    int         last_len = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    eew_target #(.WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .sda_oe_o(sda_oe), .busy_o(busy), .peek_addr_i(peek_addr), .peek_data_o(peek_data)
    );

    // measures the length of each busy episode
    always @(posedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            last_len <= busy_run;
            busy_run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(4);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = !sda_line;
        tick(H / 2);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic wait_idle();
        int guard = 0;
        tick(8);
        while (busy && guard < 5 * WRC) begin tick(1); guard++; end
        tick(4);
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < 256; a++) begin
            peek_addr = 8'(a); #1;
            chk(peek_data == exp_mem[a], req, peek_data, exp_mem[a]);
        end
    endtask

    // full write transfer; model updated with page-wrap arithmetic
    task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] seed);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack);
        chk(ack, "R2 select ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R4 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 37);
            send_byte(d, ack);
            chk(ack, "R4 data ack", ack, 1);
            exp_mem[{a[7:3], 3'(a[2:0] + 3'(k))}] = d;
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R12 reset state
        chk(sda_oe == 1'b0, "R12 oe", sda_oe, 0);
        chk(busy == 1'b0, "R12 busy", busy, 0);
        check_mem("R12 R13 array clear");

        // R1 R2 R3 select sweep over straps and address bits
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int d = 0; d < 8; d++) begin
                bus_start();
                send_byte({4'hA, 3'(d), 1'b0}, ack);
                chk(ack == (d == s), "R2 select match", ack, (d == s));
                if (d != s) begin
                    send_byte(8'h00, ack);
                    chk(!ack, "R3 standby after mismatch", ack, 0);
                end
                bus_stop();
                tick(4);
                chk(!busy, "R10 no cycle without data", busy, 0);
            end
        end
        strap = 3'd5;
        // R3 read select and wrong device code
        bus_start();
        send_byte({4'hA, 3'd5, 1'b1}, ack);
        chk(!ack, "R3 read select", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'hB, 3'd5, 1'b0}, ack);
        chk(!ack, "R3 wrong code", ack, 0);
        bus_stop();

        // R10 stop after address only
        bus_start();
        send_byte({4'hA, 3'd5, 1'b0}, ack);
        send_byte(8'h33, ack);
        chk(ack, "R4 address ack", ack, 1);
        bus_stop();
        tick(10);
        chk(!busy, "R10 stop after address", busy, 0);

        // R7 R9 byte write, bus ignored during the cycle
        page_write(8'h25, 1, 8'h5A);
        tick(2);
        chk(busy, "R7 busy after stop", busy, 1);
        bus_start();
        send_byte({4'hA, 3'd5, 1'b0}, ack);
        chk(!ack, "R9 ignored while busy", ack, 0);
        chk(busy, "R9 still busy", busy, 1);
        bus_stop();
        wait_idle();
        chk(last_len == WRC, "R7 cycle length", last_len, WRC);
        check_mem("R7 byte write");

        // R5 full page from mid page, wraps inside the page
        page_write(8'h13, 8, 8'h10);
        wait_idle();
        check_mem("R5 page wrap");

        // R8 partial write keeps the other slots of the page
        page_write(8'h16, 2, 8'hC1);
        wait_idle();
        check_mem("R8 partial page");

        // R6 overrun of eleven bytes
        page_write(8'h40, 11, 8'h77);
        wait_idle();
        check_mem("R6 overrun");

        // R11 repeated start drops buffered bytes
        bus_start();
        send_byte({4'hA, 3'd5, 1'b0}, ack);
        send_byte(8'h80, ack);
        send_byte(8'hEE, ack);
        send_byte(8'hDD, ack);
        chk(ack, "R4 data ack", ack, 1);
        bus_start();
        bus_stop();
        tick(10);
        chk(!busy, "R11 no cycle after restart", busy, 0);
        check_mem("R11 array unchanged");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule